// File: doc/BRIEF.md
# Byte Register File with Stack Engine

This block holds a 256-location byte register file for a small 8-bit processor. One access port reads and writes single bytes or 16-bit register pairs. A separate stack port pushes and pops bytes through an 8-bit stack pointer. The pointer also appears as an ordinary register at a fixed address in the system-control region. Each access address is decoded into one of four regions: general-purpose/stack, working registers, system control and peripheral control.

The sixteen working registers can only be reached in working-register mode, where a 4-bit index selects the register. A plain 8-bit address that falls in the working window is refused and flagged. A push that leaves the stack pointer outside the general-purpose area sets a sticky fault flag. The push still stores its byte. Only reset clears the flag.

Read data, pop data, the region code and the refusal flag are all registered. They appear on the clock edge after the request.

Top module: `regstk_top`

## Requirements
- R1: For every access, `acc_region` shows the region of the effective address on the next cycle. The codes are 0 for 00H–BFH (general purpose), 1 for C0H–CFH (working), 2 for D0H–DFH (system) and 3 for E0H–FFH (peripheral). The value holds when no access is made.
- R2: A byte write (`acc_we`=1, `acc_pair`=0) stores `acc_wdata[7:0]` at the clock edge. A byte read returns the stored byte on `acc_rdata[7:0]` one cycle later, with `acc_rdata[15:8]`=0. `acc_rdata` holds its value between reads.
- R3: A pair access (`acc_pair`=1) uses the even address obtained by clearing address bit 0. The write stores `acc_wdata[15:8]` at the even location and `acc_wdata[7:0]` at the next odd location. The read returns the even byte in `acc_rdata[15:8]` and the odd byte in `acc_rdata[7:0]`.
- R4: In working-register mode (`acc_wreg`=1), the effective address is C0H plus `acc_addr[3:0]`. `acc_addr[7:4]` is ignored.
- R5: A direct access (`acc_wreg`=0) whose effective address lies in C0H–CFH raises `acc_bad` for one cycle. Such a write changes nothing, and such a read returns 0.
- R6: The stack pointer is read and written at address D9H through the access port. It is also shown on `sp_q`. Its value after reset is C0H.
- R7: A push first decrements the stack pointer, then stores `stk_wdata` at the new pointer value.
- R8: A pop returns the byte at the stack pointer on `stk_rdata` one cycle later, and then increments the pointer. A pop at FFH wraps the pointer to 00H. `stk_rdata` holds its value between pops.
- R9: A push at pointer 00H wraps the pointer to FFH. Any push whose new pointer exceeds BFH sets `stk_fault`, and the byte is still stored. `stk_fault` stays set until reset.
- R10: A push or pop takes priority over an access-port write to D9H in the same cycle, and over an access-port write to the same location. When push and pop are both asserted, only the push is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access request |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_pair | input | 1 | 1 = 16-bit pair access |
| acc_wreg | input | 1 | 1 = working-register mode (4-bit index) |
| acc_addr | input | 8 | Register address or working index |
| acc_wdata | input | 16 | Write data (byte in [7:0]; pair even byte in [15:8]) |
| acc_rdata | output | 16 | Registered read data |
| acc_bad | output | 1 | Direct access to working window refused |
| acc_region | output | 2 | Region code of last access |
| stk_push | input | 1 | Push request |
| stk_pop | input | 1 | Pop request |
| stk_wdata | input | 8 | Byte to push |
| stk_rdata | output | 8 | Registered pop data |
| sp_q | output | 8 | Current stack pointer |
| stk_fault | output | 1 | Sticky stack fault |

## Verification
The hardest situations to reach are the cycles where the stack port and the access port touch the same state in the same cycle. One case is a push together with a write to D9H. Another is a push together with a write to the location being pushed. The bench drives both ports in a single cycle on purpose to create these collisions. It reaches the wrap and fault cases by first writing the stack pointer through D9H to 00H or FFH, and then pushing or popping. Refused working-window writes are confirmed by reading the same register back in working-register mode.

// File: rtl/regstk_pkg.sv
package regstk_pkg;
   typedef enum logic [1:0] {
      RGN_GP     = 2'd0,
      RGN_WORK   = 2'd1,
      RGN_SYS    = 2'd2,
      RGN_PERIPH = 2'd3
   } region_e;
endpackage

// File: rtl/rs_addr_decode.sv
module rs_addr_decode #(
   parameter int unsigned AW          = 8,
   parameter int unsigned WIN_BITS    = 4,
   parameter int unsigned WORK_BASE   = 8'hC0,
   parameter int unsigned SYS_BASE    = 8'hD0,
   parameter int unsigned PERIPH_BASE = 8'hE0
) (
   input  logic                     en,
   input  logic                     wreg,
   input  logic                     pair,
   input  logic [AW-1:0]            addr,
   output logic [AW-1:0]            eff,
   output regstk_pkg::region_e      region,
   output logic                     bad
);
   import regstk_pkg::*;
   localparam logic [AW-1:0] WB = AW'(WORK_BASE);
   localparam logic [AW-1:0] SB = AW'(SYS_BASE);
   localparam logic [AW-1:0] PB = AW'(PERIPH_BASE);

   logic [AW-1:0] raw;

   always_comb begin
      raw = wreg ? {WB[AW-1:WIN_BITS], addr[WIN_BITS-1:0]} : addr;
      eff = pair ? {raw[AW-1:1], 1'b0} : raw;
      if (eff >= PB)      region = RGN_PERIPH;
      else if (eff >= SB) region = RGN_SYS;
      else if (eff >= WB) region = RGN_WORK;
      else                region = RGN_GP;
      bad = en && !wreg && (region == RGN_WORK);
   end
endmodule

// File: rtl/rs_stack_ptr.sv
module rs_stack_ptr #(
   parameter int unsigned AW        = 8,
   parameter int unsigned SP_RESET  = 8'hC0,
   parameter int unsigned STACK_TOP = 8'hBF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic          cpu_we,
   input  logic [AW-1:0] cpu_wdata,
   output logic [AW-1:0] sp,
   output logic [AW-1:0] sp_dec,
   output logic          fault
);
   localparam logic [AW-1:0] TOP = AW'(STACK_TOP);

   assign sp_dec = sp - AW'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sp    <= AW'(SP_RESET);
         fault <= 1'b0;
      end else begin
         if (push) begin
            sp <= sp_dec;
            if (sp_dec > TOP) fault <= 1'b1;
         end else if (pop) begin
            sp <= sp + AW'(1);
         end else if (cpu_we) begin
            sp <= cpu_wdata;
         end
      end
   end
endmodule

// File: rtl/rs_byte_store.sv
module rs_byte_store #(
   parameter int unsigned AW    = 8,
   parameter int unsigned DW    = 8,
   parameter int unsigned LANES = 2,
   parameter int unsigned RPORTS = 3
) (
   input  logic                         clk,
   input  logic [LANES-1:0]             cpu_we,
   input  logic [LANES-1:0][AW-1:0]     cpu_addr,
   input  logic [LANES-1:0][DW-1:0]     cpu_data,
   input  logic                         stk_we,
   input  logic [AW-1:0]                stk_addr,
   input  logic [DW-1:0]                stk_data,
   input  logic [RPORTS-1:0][AW-1:0]    rd_addr,
   output logic [RPORTS-1:0][DW-1:0]    rd_data
);
   localparam int unsigned DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      for (int i = 0; i < LANES; i++) begin
         if (cpu_we[i]) mem[cpu_addr[i]] <= cpu_data[i];
      end
      // stack write issued last so it wins a same-address collision
      if (stk_we) mem[stk_addr] <= stk_data;
   end

   for (genvar p = 0; p < RPORTS; p++) begin : g_rd
      assign rd_data[p] = mem[rd_addr[p]];
   end
endmodule

// File: rtl/regstk_top.sv
module regstk_top #(
   parameter int unsigned AW          = 8,
   parameter int unsigned DW          = 8,
   parameter int unsigned WIN_BITS    = 4,
   parameter int unsigned WORK_BASE   = 8'hC0,
   parameter int unsigned SYS_BASE    = 8'hD0,
   parameter int unsigned PERIPH_BASE = 8'hE0,
   parameter int unsigned SP_ADDR     = 8'hD9,
   parameter int unsigned SP_RESET    = 8'hC0,
   parameter int unsigned STACK_TOP   = 8'hBF
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            acc_en,
   input  logic            acc_we,
   input  logic            acc_pair,
   input  logic            acc_wreg,
   input  logic [7:0]      acc_addr,
   input  logic [15:0]     acc_wdata,
   output logic [15:0]     acc_rdata,
   output logic            acc_bad,
   output logic [1:0]      acc_region,
   input  logic            stk_push,
   input  logic            stk_pop,
   input  logic [7:0]      stk_wdata,
   output logic [7:0]      stk_rdata,
   output logic [7:0]      sp_q,
   output logic            stk_fault
);
   import regstk_pkg::*;

   localparam int unsigned LANES  = 2;
   localparam int unsigned RPORTS = LANES + 1;
   localparam int unsigned POP_P  = LANES;
   localparam logic [AW-1:0] SPA  = AW'(SP_ADDR);

   if (AW != 8 || DW != 8) begin : g_chk_w
      $error("regstk_top: port widths assume 8-bit addresses and data");
   end
   if (!(WORK_BASE > STACK_TOP && SYS_BASE > WORK_BASE && PERIPH_BASE > SYS_BASE)) begin : g_chk_map
      $error("regstk_top: region bases must ascend above the stack area");
   end
   if (SP_ADDR < SYS_BASE || SP_ADDR >= PERIPH_BASE) begin : g_chk_sp
      $error("regstk_top: stack pointer must sit in the system region");
   end
   if (WORK_BASE % (1 << WIN_BITS) != 0) begin : g_chk_win
      $error("regstk_top: working window must be aligned to its size");
   end

   logic [AW-1:0]               eff;
   region_e                     region;
   logic                        bad;
   logic                        do_push, do_pop, wr_ok, rd_ok;
   logic [LANES-1:0]            lane_hit_sp;
   logic [LANES-1:0]            lane_act;
   logic [LANES-1:0]            lane_we;
   logic [LANES-1:0][AW-1:0]    lane_addr;
   logic [LANES-1:0][DW-1:0]    lane_wdata;
   logic [LANES-1:0][DW-1:0]    lane_rdata;
   logic [RPORTS-1:0][AW-1:0]   rd_addr;
   logic [RPORTS-1:0][DW-1:0]   rd_data;
   logic                        sp_cpu_we;
   logic [DW-1:0]               sp_cpu_data;
   logic [AW-1:0]               sp_dec;
   logic [DW-1:0]               pop_byte;

   rs_addr_decode #(
      .AW(AW), .WIN_BITS(WIN_BITS), .WORK_BASE(WORK_BASE),
      .SYS_BASE(SYS_BASE), .PERIPH_BASE(PERIPH_BASE)
   ) u_dec (
      .en(acc_en), .wreg(acc_wreg), .pair(acc_pair), .addr(acc_addr),
      .eff(eff), .region(region), .bad(bad)
   );

   assign do_push = stk_push;
   assign do_pop  = stk_pop && !stk_push;
   assign wr_ok   = acc_en && acc_we && !bad;
   assign rd_ok   = acc_en && !acc_we;

   // lane 0 is the even byte of a pair (or the lone byte), lane 1 the odd byte
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane_addr[l]   = eff | AW'(l);
      assign lane_act[l]    = (l == 0) ? 1'b1 : acc_pair;
      assign lane_hit_sp[l] = lane_act[l] && (lane_addr[l] == SPA);
      assign lane_we[l]     = wr_ok && lane_act[l] && !lane_hit_sp[l];
      if (l == 0) begin : g_even
         assign lane_wdata[l] = acc_pair ? acc_wdata[2*DW-1:DW] : acc_wdata[DW-1:0];
      end else begin : g_odd
         assign lane_wdata[l] = acc_wdata[DW-1:0];
      end
      assign rd_addr[l]    = lane_addr[l];
      assign lane_rdata[l] = (lane_addr[l] == SPA) ? sp_q : rd_data[l];
   end

   assign rd_addr[POP_P] = sp_q;
   assign pop_byte       = (sp_q == SPA) ? sp_q : rd_data[POP_P];

   always_comb begin
      sp_cpu_we   = 1'b0;
      sp_cpu_data = '0;
      for (int l = 0; l < LANES; l++) begin
         if (wr_ok && lane_hit_sp[l]) begin
            sp_cpu_we   = 1'b1;
            sp_cpu_data = lane_wdata[l];
         end
      end
   end

   rs_stack_ptr #(
      .AW(AW), .SP_RESET(SP_RESET), .STACK_TOP(STACK_TOP)
   ) u_sp (
      .clk(clk), .rst_n(rst_n), .push(do_push), .pop(do_pop),
      .cpu_we(sp_cpu_we), .cpu_wdata(sp_cpu_data),
      .sp(sp_q), .sp_dec(sp_dec), .fault(stk_fault)
   );

   rs_byte_store #(
      .AW(AW), .DW(DW), .LANES(LANES), .RPORTS(RPORTS)
   ) u_store (
      .clk(clk), .cpu_we(lane_we), .cpu_addr(lane_addr), .cpu_data(lane_wdata),
      .stk_we(do_push), .stk_addr(sp_dec), .stk_data(stk_wdata),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_rdata  <= '0;
         acc_bad    <= 1'b0;
         acc_region <= RGN_GP;
         stk_rdata  <= '0;
      end else begin
         acc_bad <= bad;
         if (acc_en) acc_region <= region;
         if (rd_ok) begin
            if (bad)           acc_rdata <= '0;
            else if (acc_pair) acc_rdata <= {lane_rdata[0], lane_rdata[1]};
            else               acc_rdata <= {{DW{1'b0}}, lane_rdata[0]};
         end
         if (do_pop) stk_rdata <= pop_byte;
      end
   end
endmodule

// File: rtl/regstk_chk.sv
module regstk_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        acc_en,
   input logic        acc_wreg,
   input logic [7:0]  acc_addr,
   input logic        acc_bad,
   input logic [1:0]  acc_region,
   input logic        stk_push,
   input logic        stk_pop,
   input logic [7:0]  sp_q,
   input logic        stk_fault
);
   // R7
   push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stk_push |=> sp_q == 8'($past(sp_q) - 8'd1));
   // R8
   pop_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_pop && !stk_push) |=> sp_q == 8'($past(sp_q) + 8'd1));
   // R9
   fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stk_fault |=> stk_fault);
   // R9
   wrap_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_push && sp_q == 8'h00) |=> (stk_fault && sp_q == 8'hFF));
   // R5
   bad_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && !acc_wreg && acc_addr[7:4] == 4'hC) |=> acc_bad);
   // R4
   wreg_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && acc_wreg) |=> (!acc_bad && acc_region == 2'd1));
   // R5
   bad_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_en |=> !acc_bad);
endmodule

bind regstk_top regstk_chk u_chk (
   .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wreg(acc_wreg),
   .acc_addr(acc_addr), .acc_bad(acc_bad), .acc_region(acc_region),
   .stk_push(stk_push), .stk_pop(stk_pop), .sp_q(sp_q), .stk_fault(stk_fault)
);

// File: tb/sim_regstk_top.sv
module sim_regstk_top;
   logic clk = 0, rst_n = 0;
   logic acc_en = 0, acc_we = 0, acc_pair = 0, acc_wreg = 0;
   logic [7:0] acc_addr = 0;
   logic [15:0] acc_wdata = 0;
   logic [15:0] acc_rdata;
   logic acc_bad;
   logic [1:0] acc_region;
   logic stk_push = 0, stk_pop = 0;
   logic [7:0] stk_wdata = 0, stk_rdata, sp_q;
   logic stk_fault;

   always #5 clk = ~clk;

   regstk_top u0 (.*);

   int checks = 0, fails = 0;
   bit done = 0;

   // behavioural reference state
   logic [7:0]  m_mem [256];
   logic [7:0]  m_sp;
   logic        m_fault, m_bad;
   logic [15:0] m_rdata;
   logic [7:0]  m_srd;
   logic [1:0]  m_region;

   function automatic logic [7:0] m_rd(input logic [7:0] a);
      return (a == 8'hD9) ? m_sp : m_mem[a];
   endfunction

   task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      chk(tag, "sp_q", {8'h0, sp_q}, {8'h0, m_sp});
      chk(tag, "stk_fault", {15'h0, stk_fault}, {15'h0, m_fault});
      chk(tag, "acc_bad", {15'h0, acc_bad}, {15'h0, m_bad});
      chk(tag, "acc_rdata", acc_rdata, m_rdata);
      chk(tag, "acc_region", {14'h0, acc_region}, {14'h0, m_region});
      chk(tag, "stk_rdata", {8'h0, stk_rdata}, {8'h0, m_srd});
   endtask

   task automatic do_reset(input string tag);
      rst_n = 0; acc_en = 0; stk_push = 0; stk_pop = 0;
      @(posedge clk); @(posedge clk); @(negedge clk);
      rst_n = 1;
      m_sp = 8'hC0; m_fault = 0; m_bad = 0; m_rdata = 0; m_srd = 0; m_region = 0;
      compare(tag);
   endtask

   // one cycle on both ports; called at a falling edge
   task automatic step(input logic en, input logic we, input logic pair, input logic wreg,
                       input logic [7:0] addr, input logic [15:0] wd,
                       input logic push, input logic pop, input logic [7:0] sd, input string tag);
      logic [7:0] eff, nsp, spw;
      logic bad, spwe;
      acc_en = en; acc_we = we; acc_pair = pair; acc_wreg = wreg;
      acc_addr = addr; acc_wdata = wd; stk_push = push; stk_pop = pop; stk_wdata = sd;
      eff = wreg ? {4'hC, addr[3:0]} : addr;
      if (pair) eff[0] = 1'b0;
      bad = en && !wreg && eff >= 8'hC0 && eff <= 8'hCF;
      if (en) m_region = (eff >= 8'hE0) ? 2'd3 : (eff >= 8'hD0) ? 2'd2 : (eff >= 8'hC0) ? 2'd1 : 2'd0;
      if (en && !we)
         m_rdata = bad ? 16'h0 : pair ? {m_rd(eff), m_rd(eff + 8'd1)} : {8'h0, m_rd(eff)};
      if (pop && !push) m_srd = m_rd(m_sp);
      spwe = 0; spw = 0;
      if (en && we && !bad) begin
         if (pair) begin
            if (eff == 8'hD9) begin spwe = 1; spw = wd[15:8]; end else m_mem[eff] = wd[15:8];
            if (eff + 8'd1 == 8'hD9) begin spwe = 1; spw = wd[7:0]; end else m_mem[eff + 8'd1] = wd[7:0];
         end else begin
            if (eff == 8'hD9) begin spwe = 1; spw = wd[7:0]; end else m_mem[eff] = wd[7:0];
         end
      end
      if (push) begin
         nsp = m_sp - 8'd1;
         m_mem[nsp] = sd;
         if (nsp > 8'hBF) m_fault = 1;
         m_sp = nsp;
      end else if (pop) m_sp = m_sp + 8'd1;
      else if (spwe) m_sp = spw;
      m_bad = bad;
      @(posedge clk); @(negedge clk);
      acc_en = 0; stk_push = 0; stk_pop = 0;
      compare(tag);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
      step(1, 1, 0, 0, a, {8'h0, d}, 0, 0, 0, tag);
   endtask
   task automatic rd(input logic [7:0] a, input string tag);
      step(1, 0, 0, 0, a, 0, 0, 0, 0, tag);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", checks, fails);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      do_reset("R6 reset");
      // R2 byte write and read, R1 general-purpose region
      wr(8'h10, 8'hA5, "R2 write");
      rd(8'h10, "R2 read");
      rd(8'hBF, "R1 top of gp");
      // R4 working-register mode, upper address bits ignored
      step(1, 1, 0, 1, 8'h05, 16'h003C, 0, 0, 0, "R4 wreg write");
      step(1, 0, 0, 1, 8'hF5, 0, 0, 0, 0, "R4 wreg read");
      // R5 direct access to working window refused
      rd(8'hC5, "R5 bad read");
      wr(8'hC5, 8'hFF, "R5 bad write");
      step(1, 0, 0, 1, 8'h05, 0, 0, 0, 0, "R5 unchanged");
      step(1, 0, 1, 0, 8'hC3, 0, 0, 0, 0, "R5 bad pair");
      // R3 pair access, odd address bit ignored
      step(1, 1, 1, 0, 8'h21, 16'h1234, 0, 0, 0, "R3 pair write");
      rd(8'h20, "R3 even byte");
      rd(8'h21, "R3 odd byte");
      step(1, 0, 1, 0, 8'h20, 0, 0, 0, 0, "R3 pair read");
      step(1, 1, 1, 1, 8'h0B, 16'hBEEF, 0, 0, 0, "R3 wreg pair write");
      step(1, 0, 1, 1, 8'h0A, 0, 0, 0, 0, "R3 wreg pair read");
      // R1 system and peripheral regions
      wr(8'hD0, 8'h11, "R1 sys");
      wr(8'hE7, 8'h5A, "R1 periph");
      rd(8'hE7, "R1 periph read");
      rd(8'hDF, "R1 sys top");
      // R6 stack pointer through port
      rd(8'hD9, "R6 sp read");
      wr(8'hD9, 8'h40, "R6 sp write");
      rd(8'hD9, "R6 sp readback");
      // R7 R8 push/pop, call-style two bytes and reverse return
      step(0, 0, 0, 0, 0, 0, 1, 0, 8'h11, "R7 push hi");
      step(0, 0, 0, 0, 0, 0, 1, 0, 8'h22, "R7 push lo");
      rd(8'h3E, "R7 stored at new sp");
      step(0, 0, 0, 0, 0, 0, 0, 1, 0, "R8 pop lo");
      step(0, 0, 0, 0, 0, 0, 0, 1, 0, "R8 pop hi");
      // R10 priority cases
      step(1, 1, 0, 0, 8'hD9, 16'h0090, 1, 0, 8'h33, "R10 push beats sp write");
      step(1, 1, 0, 0, 8'hD9, 16'h0090, 0, 1, 0, "R10 pop beats sp write");
      step(1, 1, 0, 0, 8'h3F, 16'h00EE, 1, 0, 8'h44, "R10 push beats same-address write");
      rd(8'h3F, "R10 same-address value");
      step(0, 0, 0, 0, 0, 0, 1, 1, 8'h55, "R10 push beats pop");
      // R8 pop wrap FF to 00
      wr(8'hFF, 8'h77, "R8 seed");
      wr(8'hD9, 8'hFF, "R8 sp to FF");
      step(0, 0, 0, 0, 0, 0, 0, 1, 0, "R8 pop wrap");
      // R9 push wrap 00 to FF with fault, byte still stored
      wr(8'hD9, 8'h00, "R9 sp to 00");
      step(0, 0, 0, 0, 0, 0, 1, 0, 8'h99, "R9 push wrap");
      rd(8'hFF, "R9 write performed");
      wr(8'hD9, 8'h50, "R9 fault sticky");
      step(0, 0, 0, 0, 0, 0, 1, 0, 8'h01, "R9 still sticky");
      do_reset("R9 fault cleared by reset");
      wr(8'hD9, 8'hC6, "R9 sp above stack");
      step(0, 0, 0, 0, 0, 0, 1, 0, 8'h02, "R9 push above top");
      step(0, 0, 0, 0, 0, 0, 0, 1, 0, "R8 pop above top");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end
endmodule